// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Hold Latches

This block is a serial scan chain built for two-pattern delay testing of a combinational logic cone. Each chain stage pairs a scan flip-flop with a level-sensitive hold latch. The latch sits between the flip-flop and the logic input that the stage drives. While the hold control is low the latch is transparent, so the logic sees the flip-flop value directly. While hold is high the latch keeps its last value, and the flip-flops are free to shift.

A test runs in five steps. The initialising vector is shifted in with hold low, so it settles on the logic inputs. Hold is then raised and the launch vector is shifted in behind the frozen latches. Dropping hold applies the launch vector to the logic in one step. The stage that is in normal mode captures the logic response on the next system clock edge. Finally, the response is shifted out serially.

Stage 0 takes the serial input. Stage i takes stage i-1 during a shift. The serial output is the flip-flop of the last stage, so a vector bit meant for stage k has to be shifted in at position N-1-k of an N-bit shift sequence.

Top module: `tp_scan_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every flip-flop clears to 0. While `rst` is high, every hold latch reads 0. After that edge, `vec_out` and `so` are both 0.
- R2: When `test_mode` is 1 (scan) at a clock edge, stage 0 loads `si` and each stage i>0 loads the old value of stage i-1.
- R3: When `test_mode` is 0 (normal) at a clock edge, stage i loads `resp_in[i]`.
- R4: While `hold` is 0, `vec_out[i]` equals the current flip-flop value of stage i. This also holds during shifting and capture.
- R5: While `hold` is 1, `vec_out` does not change, whatever shifting or capture happens in the flip-flops.
- R6: `so` is always the flip-flop of stage N-1, never its latch. So `so` changes on a scan shift even while hold is 1.
- R7: When `hold` falls, `vec_out` takes the flip-flop contents at once, without waiting for a clock edge. This launches the second vector.
- R8: A full sequence returns the response that was captured from the launch vector. The sequence is: load V1, hold, load V2, release hold, capture one clock later, shift out. The shift-out presents stage N-1 first, then N-2, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset for the flip-flops; it also clears the latches |
| test_mode | input | 1 | 1 = scan shift, 0 = normal capture |
| hold | input | 1 | 1 = latches freeze, 0 = latches transparent |
| si | input | 1 | Serial scan input into stage 0 |
| resp_in | input | N | Response from the logic under test, one bit per stage |
| vec_out | output | N | Latched vector presented to the logic under test |
| so | output | 1 | Serial scan output from the stage N-1 flip-flop |

## Verification
The bench targets the following corner cases:
- Hold stays high across a complete second-vector shift. A latch that leaks would show the shifting pattern on `vec_out`.
- Hold falls between clock edges. A design that made the latch edge-triggered would launch late, and the immediate post-release sample would catch it.
- The serial output is watched while hold is high. Wiring `so` to the latch instead of the flip-flop would freeze it.
- Capture and shift-out are compared bit by bit against a response function that the bench computes. A reversed shift order or a wrong capture mux would garble the returned word.

// File: rtl/tp_scan_pkg.sv
package tp_scan_pkg;

    typedef enum logic {
        TM_NORMAL = 1'b0,
        TM_SCAN   = 1'b1
    } test_mode_e;

    typedef struct packed {
        logic ser;
        logic cap;
    } stage_in_t;

    function automatic logic pick_next(test_mode_e m, stage_in_t in);
        return (m == TM_SCAN) ? in.ser : in.cap;
    endfunction

endpackage

// File: rtl/tp_scan_cell.sv
module tp_scan_cell
    import tp_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  test_mode_e mode,
    input  stage_in_t  din,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= pick_next(mode, din);
    end
endmodule

// File: rtl/tp_hold_latch.sv
module tp_hold_latch (
    input  logic rst,
    input  logic hold,
    input  logic d,
    output logic q
);
    always_latch begin
        if (rst)
            q <= 1'b0;
        else if (!hold)
            q <= d;
    end
endmodule

// File: rtl/tp_scan_chain.sv
module tp_scan_chain
    import tp_scan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         test_mode,
    input  logic         hold,
    input  logic         si,
    input  logic [N-1:0] resp_in,
    output logic [N-1:0] vec_out,
    output logic         so
);
    localparam int LAST = N - 1;

    test_mode_e   mode;
    logic [N-1:0] ff_q;
    logic [N-1:0] ser_src;

    assign mode    = test_mode_e'(test_mode);
    assign ser_src = {ff_q[N-2:0], si};

    for (genvar g = 0; g < N; g++) begin : g_stage
        stage_in_t sin;
        assign sin.ser = ser_src[g];
        assign sin.cap = resp_in[g];

        tp_scan_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .din  (sin),
            .q    (ff_q[g])
        );

        tp_hold_latch u_latch (
            .rst  (rst),
            .hold (hold),
            .d    (ff_q[g]),
            .q    (vec_out[g])
        );
    end

    assign so = ff_q[LAST];

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (ff_q == '0 && vec_out == '0));

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(test_mode)) |-> (ff_q == {$past(ff_q[N-2:0]), $past(si)}));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(test_mode)) |-> (ff_q == $past(resp_in)));

    assert_transparent_R4: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (vec_out == ff_q));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && hold && $past(hold)) |-> $stable(vec_out));

endmodule

// File: tb/tp_scan_chain_bench.sv
module tp_scan_chain_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_mode = 1'b0;
    logic         hold = 1'b0;
    logic         si = 1'b0;
    logic [N-1:0] resp_in = '0;
    logic [N-1:0] vec_out;
    logic         so;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_ff;
    logic [N-1:0] m_lat;

    always #2.5 clk = ~clk;

    tp_scan_chain #(.N(N)) u_tp_scan_chain (
        .clk(clk), .rst(rst), .test_mode(test_mode), .hold(hold),
        .si(si), .resp_in(resp_in), .vec_out(vec_out), .so(so)
    );

    function automatic logic [N-1:0] logic_fn(logic [N-1:0] v);
        return {v[N-2:0], v[N-1]} ^ 8'h5A;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, clock once, sample 1 ns after the edge
    task automatic step(logic tm, logic h, logic s, logic [N-1:0] cap);
        @(negedge clk);
        test_mode = tm; hold = h; si = s; resp_in = cap;
        if (!h) m_lat = m_ff;
        @(posedge clk);
        if (tm) m_ff = {m_ff[N-2:0], s};
        else    m_ff = cap;
        if (!h) m_lat = m_ff;
        #1;
        chk(h ? "R5" : "R4", vec_out, m_lat);
        chk("R6", {7'b0, so}, {7'b0, m_ff[N-1]});
    endtask

    task automatic load(logic h, logic [N-1:0] v);
        for (int k = 0; k < N; k++) step(1'b1, h, v[N-1-k], '0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_ff = '0; m_lat = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", vec_out, '0);
        chk("R1", {7'b0, so}, 8'h00);
        @(negedge clk); rst = 1'b0;

        // directed: shift a known pattern, hold low
        load(1'b0, 8'hB3);
        chk("R2", vec_out, 8'hB3);

        // capture in normal mode
        step(1'b0, 1'b0, 1'b0, 8'h6C);
        chk("R3", vec_out, 8'h6C);

        // full two-pattern runs, directed then random
        for (int t = 0; t < 12; t++) begin
            logic [N-1:0] v1, v2, rsp, got;
            v1 = (t == 0) ? 8'h00 : (t == 1) ? 8'hFF : N'($urandom);
            v2 = (t == 0) ? 8'hFF : (t == 1) ? 8'h00 : N'($urandom);
            load(1'b0, v1);
            chk("R4", vec_out, v1);
            load(1'b1, v2);
            chk("R5", vec_out, v1);
            chk("R6", {7'b0, so}, {7'b0, v2[N-1]});
            // release hold between edges: launch is immediate
            @(negedge clk);
            test_mode = 1'b0; resp_in = logic_fn(v2); hold = 1'b0;
            m_lat = m_ff;
            #1;
            chk("R7", vec_out, v2);
            @(posedge clk);
            m_ff = logic_fn(v2); m_lat = m_ff;
            #1;
            rsp = logic_fn(v2);
            got = '0;
            for (int k = 0; k < N; k++) begin
                got[N-1-k] = so;
                step(1'b1, 1'b1, N'($urandom) & 1'b1, '0);
            end
            chk("R8", got, rsp);
        end

        // random mixed operation
        for (int t = 0; t < 300; t++)
            step(1'($urandom), 1'($urandom), 1'($urandom), N'($urandom));

        // reset in mid operation with hold high
        @(negedge clk); rst = 1'b1; hold = 1'b1;
        @(posedge clk); #1;
        chk("R1", vec_out, '0);
        chk("R1", {7'b0, so}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule